// File: doc/BRIEF.md
# Divider and Reloadable Interval Timer

This block is a small byte-wide timer peripheral. It keeps a free-running prescaler on the CPU clock. The upper byte of that prescaler is visible as a divider that steps once every 256 clocks. A second 8-bit counter steps at one of four divided rates, chosen by a control register. When that counter passes 0xFF, it takes its next value from a modulo register and emits a one-clock interrupt request. Software programs a modulo of 0x100−N to get an interrupt every N steps.

A simple byte bus reaches the four registers through a 2-bit address. The register offsets are 0 = divider, 1 = counter, 2 = modulo and 3 = control. The read data is registered, so it shows the addressed register as it stood in the previous cycle. A stop input holds the whole prescaler at zero. When stop is released, counting restarts from zero.

Top module: `interval_timer`

## Requirements
- R1: After the prescaler starts from zero, the divider (offset 0) reads floor(n/256) mod 256, where n is the number of clocks counted since the start.
- R2: A write of any data value to offset 0 clears the whole prescaler, so the divider becomes 0x00 and counting restarts from zero.
- R3: While stop_mode is 1, the prescaler is held at zero. Counting restarts from zero once stop_mode returns to 0.
- R4: The divider counts whatever the value of the timer enable bit.
- R5: The counter (offset 1) steps only when control bit 2 is 1. With bit 2 at 0, it keeps its value and no interrupt is raised.
- R6: Control bits [1:0] pick the counter step period P: 00 gives 1024 clocks, 01 gives 16, 10 gives 64 and 11 gives 256. After counting restarts from zero, a step takes effect at each clock k with k = P/2 + m·P.
- R7: A step taken at 0xFF loads the counter from the modulo register (offset 2). It also asserts irq for exactly one cycle, in the cycle after the step.
- R8: A modulo value of 0xFF makes every step an overflow. A modulo value of 0x100−N gives one interrupt per N steps.
- R9: A modulo write in the same cycle as an overflow reload stores the new modulo value, but the counter receives the old one.
- R10: A counter write in the same cycle as a step loads the written data. No reload and no interrupt happen in that cycle.
- R11: The control register (offset 3) reads back bits [7:3] as 1, with bits [2:0] as written. bus_rdata shows the register selected by bus_addr one cycle after the address is applied.
- R12: Reset clears the prescaler, the counter, the modulo, the control register, irq and bus_rdata. After reset, the control register reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset for read and write |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data of the addressed register |
| stop_mode | input | 1 | Holds the prescaler at zero while 1 |
| irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The properties assume that the rate select bits change only while stop_mode holds the prescaler at zero. A change of tap while the prescaler runs can start a step at an arbitrary point. The properties also assume that writes are single-cycle strobes. The stimulus programs the control, modulo and counter registers only while stop is held, and then releases stop. Because of this, every step lands at a clock count the bench can compute from the chosen rate. The two collision cases are hit by placing a write in the exact cycle of the first step after release.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_RATES = 4;
  localparam int CTL_W     = 3;
  localparam int CTL_EN    = 2;

  typedef enum logic [1:0] {
    OFS_DIV = 2'd0,
    OFS_CNT = 2'd1,
    OFS_MOD = 2'd2,
    OFS_CTL = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DATA_W  = 8,
  parameter int DIV_LSB = 8,
  parameter int NRATE   = 4,
  parameter logic [NRATE*8-1:0] TAPS = {8'd7, 8'd5, 8'd3, 8'd9}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              hold,
  output logic [DATA_W-1:0] div_byte,
  output logic [NRATE-1:0]  tap_bits
);
  localparam int PRESC_W = DIV_LSB + DATA_W;

  logic [PRESC_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear || hold) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end

  assign div_byte = cnt[DIV_LSB +: DATA_W];

  for (genvar g = 0; g < NRATE; g++) begin : g_tap
    localparam int TI = int'(TAPS[g*8 +: 8]);
    assign tap_bits[g] = cnt[TI];
  end
endmodule

// File: rtl/tmr_rate_sel.sv
module tmr_rate_sel #(
  parameter int NRATE = 4,
  localparam int SEL_W = $clog2(NRATE)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NRATE-1:0] tap_bits,
  input  logic [SEL_W-1:0] sel,
  input  logic             enable,
  output logic             tick
);
  logic tap_now;
  logic tap_q;

  assign tap_now = tap_bits[sel];

  always_ff @(posedge clk) begin
    if (rst) tap_q <= 1'b0;
    else     tap_q <= tap_now;
  end

  assign tick = enable && tap_now && !tap_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cnt_we,
  input  logic              mod_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] modulo,
  output logic              irq
);
  localparam logic [DATA_W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      modulo <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mod_we) modulo <= wdata;
      if (cnt_we) begin
        count <= wdata;
      end else if (tick) begin
        if (count == TOP) begin
          count <= modulo;
          irq   <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIV_LSB = 8,
  parameter int ADDR_W  = 2,
  parameter logic [NUM_RATES*8-1:0] RATE_TAPS = {8'd7, 8'd5, 8'd3, 8'd9}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              stop_mode,
  output logic              irq
);
  localparam int SEL_W = $clog2(NUM_RATES);

  logic                 wr_div, wr_cnt, wr_mod, wr_ctl;
  logic [DATA_W-1:0]    div_byte, tmr_cnt, tmr_mod, rd_mux;
  logic [NUM_RATES-1:0] tap_bits;
  logic [CTL_W-1:0]     ctl_q;
  logic                 tick;

  assign wr_div = bus_wr && (bus_addr == ADDR_W'(OFS_DIV));
  assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(OFS_CNT));
  assign wr_mod = bus_wr && (bus_addr == ADDR_W'(OFS_MOD));
  assign wr_ctl = bus_wr && (bus_addr == ADDR_W'(OFS_CTL));

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (wr_ctl) ctl_q <= bus_wdata[CTL_W-1:0];
  end

  tmr_prescaler #(
    .DATA_W(DATA_W), .DIV_LSB(DIV_LSB), .NRATE(NUM_RATES), .TAPS(RATE_TAPS)
  ) u_presc (
    .clk(clk), .rst(rst), .clear(wr_div), .hold(stop_mode),
    .div_byte(div_byte), .tap_bits(tap_bits)
  );

  tmr_rate_sel #(.NRATE(NUM_RATES)) u_rate (
    .clk(clk), .rst(rst), .tap_bits(tap_bits),
    .sel(ctl_q[SEL_W-1:0]), .enable(ctl_q[CTL_EN]), .tick(tick)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .cnt_we(wr_cnt), .mod_we(wr_mod),
    .wdata(bus_wdata), .count(tmr_cnt), .modulo(tmr_mod), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_DIV): rd_mux = div_byte;
      ADDR_W'(OFS_CNT): rd_mux = tmr_cnt;
      ADDR_W'(OFS_MOD): rd_mux = tmr_mod;
      default:          rd_mux = {{(DATA_W-CTL_W){1'b1}}, ctl_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              stop_mode,
  input logic              irq,
  input logic [DATA_W-1:0] div_val,
  input logic [DATA_W-1:0] cnt_val,
  input logic [DATA_W-1:0] mod_val,
  input logic              ctl_en,
  input logic              tick
);
  logic cnt_w, div_w;
  assign cnt_w = bus_wr && (bus_addr == ADDR_W'(1));
  assign div_w = bus_wr && (bus_addr == ADDR_W'(0));

  p_div_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!stop_mode && !div_w) |=> ((div_val == $past(div_val)) ||
                                (div_val == DATA_W'($past(div_val) + 1'b1))));

  p_div_clear_r2: assert property (@(posedge clk) disable iff (rst)
    div_w |=> (div_val == '0));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    stop_mode |=> (div_val == '0));

  p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_en && !cnt_w) |=> ($stable(cnt_val) && !irq));

  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_w && (cnt_val != '1)) |=> (cnt_val == DATA_W'($past(cnt_val) + 1'b1)));

  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_w && (cnt_val == '1)) |=> (irq && (cnt_val == $past(mod_val))));

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_wr_prio_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_w |=> ((cnt_val == $past(bus_wdata)) && !irq));

  p_ctl_ones_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(3)) |=> (bus_rdata[DATA_W-1:3] == '1));
endmodule

bind interval_timer interval_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_mode(stop_mode),
  .irq(irq), .div_val(div_byte), .cnt_val(tmr_cnt), .mod_val(tmr_mod),
  .ctl_en(ctl_q[2]), .tick(tick)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       stop_mode = 1'b0;
  logic       irq;

  int checks = 0;
  int fails = 0;
  int irq_total = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stop_mode(stop_mode), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_total++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    v = bus_rdata;
  endtask

  function automatic void model(input int start, input int md, input int incs,
                                output int v, output int ovf);
    v = start; ovf = 0;
    for (int i = 0; i < incs; i++) begin
      if (v == 255) begin v = md; ovf++; end
      else v = v + 1;
    end
  endfunction

  task automatic run_timer(input logic [7:0] ctl, input logic [7:0] start,
                           input logic [7:0] md, input int k_edges,
                           output logic [7:0] got, output int got_irq);
    int base;
    stop_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(2'd3, ctl); wr(2'd2, md); wr(2'd1, start);
    base = irq_total;
    stop_mode = 1'b0;
    repeat (k_edges) @(posedge clk);
    @(negedge clk);
    stop_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(2'd1, got);
    got_irq = irq_total - base;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int got_irq, exp_v, exp_ovf, incs, per, half, base;
    int periods [4] = '{1024, 16, 64, 256};
    int mods [4] = '{255, 254, 253, 128};

    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 rdata in reset", bus_rdata, 0);
    rst = 1'b0;
    rd(2'd0, v); check("R12 divider after reset", v, 0);
    rd(2'd1, v); check("R12 counter after reset", v, 0);
    rd(2'd2, v); check("R12 modulo after reset", v, 0);
    rd(2'd3, v); check("R12 control after reset", v, 8'hF8);

    // R11: control readback
    wr(2'd3, 8'h05); rd(2'd3, v); check("R11 control 0x05", v, 8'hFD);
    wr(2'd3, 8'hFA); rd(2'd3, v); check("R11 control 0xFA", v, 8'hFA);

    // R1 R2 R4: divider with enable off, then on
    for (int pass = 0; pass < 2; pass++) begin
      wr(2'd3, pass == 0 ? 8'h00 : 8'h07);
      wr(2'd0, pass == 0 ? 8'h5A : 8'hFF);
      repeat (256) @(posedge clk);
      @(negedge clk);
      check(pass == 0 ? "R2 divider cleared" : "R4 divider cleared enabled", bus_rdata, 0);
      @(posedge clk); @(negedge clk);
      check(pass == 0 ? "R1 divider first step" : "R4 divider first step", bus_rdata, 1);
      repeat (512) @(posedge clk);
      @(negedge clk);
      check("R1 divider after 768", bus_rdata, 3);
    end

    // R3: stop holds prescaler at zero
    stop_mode = 1'b1;
    repeat (600) @(posedge clk);
    @(negedge clk);
    rd(2'd0, v); check("R3 divider held in stop", v, 0);
    stop_mode = 1'b0;
    repeat (300) @(posedge clk);
    @(negedge clk);
    check("R3 divider after stop release", bus_rdata, 1);

    // R6: first step boundary for each rate
    for (int s = 0; s < 4; s++) begin
      half = periods[s] / 2;
      run_timer(8'h04 | 8'(s), 8'h10, 8'h00, half - 1, v, got_irq);
      check("R6 no step before P/2", v, 8'h10);
      run_timer(8'h04 | 8'(s), 8'h10, 8'h00, half, v, got_irq);
      check("R6 step at P/2", v, 8'h11);
    end

    // R6 R7 R8: sweep of rates and modulo values
    for (int s = 0; s < 4; s++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int kk;
        per = periods[s]; half = per / 2;
        kk = 6 * per + 3;
        incs = (kk - half) / per + 1;
        model(252, mods[mi], incs, exp_v, exp_ovf);
        run_timer(8'h04 | 8'(s), 8'd252, 8'(mods[mi]), kk, v, got_irq);
        check("R6 R7 counter after sweep run", v, exp_v);
        check(mods[mi] == 255 ? "R8 irq per step" : "R8 irq count", got_irq, exp_ovf);
      end
    end

    // R5: disabled counter does not move
    run_timer(8'h01, 8'h12, 8'hFF, 200, v, got_irq);
    check("R5 counter disabled", v, 8'h12);
    check("R5 no irq disabled", got_irq, 0);

    // R9: modulo write collides with reload
    stop_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(2'd3, 8'h05); wr(2'd2, 8'h40); wr(2'd1, 8'hFF);
    base = irq_total;
    stop_mode = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 8'h99; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; stop_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R9 counter takes old modulo", v, 8'h40);
    rd(2'd2, v); check("R9 modulo takes new value", v, 8'h99);
    check("R9 irq on collision reload", irq_total - base, 1);

    // R10: counter write collides with step
    wr(2'd2, 8'h40); wr(2'd1, 8'hFF);
    base = irq_total;
    stop_mode = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 8'h33; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; stop_mode = 1'b1;
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R10 counter write wins", v, 8'h33);
    check("R10 no irq on write", irq_total - base, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule